// File: doc/BRIEF.md
# Message Object Transfer Engine

This block sits between a host register window and a RAM of message objects used by a CAN controller. Each object holds five sections: an acceptance mask, an arbitration word, a 16-bit control word and two 32-bit data words. The host first loads a set of interface registers, one per section. It then writes a single command word that names an object and the sections to move. The engine performs the transfer in the background and raises a busy flag until it is done. The host polls that flag before it issues its next command.

A command either writes the selected interface registers into the object or reads the selected object sections into the interface registers. Bit 2 of the command mask acts on whichever side the command is going. On a read it clears the object's new-data flag. On a write it sets the object's transmit request. On a read, bit 3 also clears the interrupt-pending flag. These clear and set actions are applied to the stored object within the same transfer.

The engine does not interpret the arbitration word. Message-valid at bit 31, extended identifier at bit 30, direction at bit 29 and the identifier field are stored as written.

Top module: `msgxfer_engine`

## Requirements
- R1: After reset, busy is low and every register in the window reads zero.
- R2: A write to address 0 starts a transfer when the engine is idle. Bits 23:16 of that write carry the command mask and bits 5:0 carry the object number. Objects 1 to NUM_OBJ (default 32) are valid, including the last one.
- R3: Busy rises at the clock edge that accepts a command and stays high for exactly two cycles. The same flag is readable at bit 15 of address 0.
- R4: A write transfer (mask bit 7 = 1) copies each selected interface register into the object and leaves the other object sections unchanged. The section selects are bit 6 mask, bit 5 arbitration, bit 4 control, bit 1 data A and bit 0 data B.
- R5: In a write transfer, mask bit 2 sets the object's transmit request (control bit 8), even when the control section is not selected. Mask bit 3 has no effect on a write.
- R6: A read transfer (mask bit 7 = 0) copies only the selected object sections into the interface registers, using the same section bits as R4. Interface registers that are not selected keep their value.
- R7: In a read transfer, mask bit 3 clears interrupt-pending (control bit 13) and mask bit 2 clears new-data (control bit 15) in the stored object. The copy in the interface register shows the values from before the clear.
- R8: A command naming object 0 or an object above NUM_OBJ is not accepted. Busy stays low and nothing changes.
- R9: While busy is high, commands and writes to the interface registers are ignored.
- R10: A read request returns data on rd_data one cycle later. The addresses are 1 mask, 2 arbitration, 3 control (zero-extended), 4 data A and 5 data B. Address 0 returns {8'h00, last accepted mask, busy, 9'b0, last accepted object}. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| busy | output | 1 | Transfer in progress |

## Verification
When a command is accepted at edge E0, busy is high after E0 and after E1 and falls after E2. The interface registers and the stored object both take their new values at E2. A read sampled at an edge shows on rd_data after that edge, using the state from before the edge. The bench keeps a behavioural model that steps once per rising edge in exactly these terms. It drives inputs on falling edges and compares busy on every falling edge. It compares rd_data on the falling edge that follows each read request. This lets it check reads made in the middle of a transfer as well as commands that arrive while busy.

// File: rtl/msgxfer_pkg.sv
package msgxfer_pkg;

  localparam int SEC_W = 32;
  localparam int CTL_W = 16;

  // command mask bit positions
  localparam int CM_DIR  = 7;
  localparam int CM_MSK  = 6;
  localparam int CM_ARB  = 5;
  localparam int CM_CTL  = 4;
  localparam int CM_CIP  = 3;
  localparam int CM_TXND = 2;
  localparam int CM_DA   = 1;
  localparam int CM_DB   = 0;

  // control word flag positions touched by the engine
  localparam int MC_NEWDAT = 15;
  localparam int MC_INTPND = 13;
  localparam int MC_TXRQ   = 8;

  typedef struct packed {
    logic [SEC_W-1:0] msk;
    logic [SEC_W-1:0] arb;
    logic [CTL_W-1:0] ctl;
    logic [SEC_W-1:0] da;
    logic [SEC_W-1:0] db;
  } obj_t;

  typedef enum logic [2:0] {
    RA_CMD = 3'd0,
    RA_MSK = 3'd1,
    RA_ARB = 3'd2,
    RA_CTL = 3'd3,
    RA_DA  = 3'd4,
    RA_DB  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_FETCH = 2'd1,
    XS_APPLY = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/msgxfer_ram.sv
module msgxfer_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 144,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/msgxfer_ctrl.sv
module msgxfer_ctrl
  import msgxfer_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int OBJ_W = $clog2(NUM_OBJ + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_mask_in,
  input  logic [OBJ_W-1:0] cmd_obj_in,
  output logic             busy,
  output logic             apply,
  output logic [7:0]       cmd_q,
  output logic [OBJ_W-1:0] obj_q
);

  xfer_state_e state;
  logic        obj_ok;
  logic        accept;

  assign obj_ok = (cmd_obj_in != '0) && (cmd_obj_in <= OBJ_W'(NUM_OBJ));
  assign accept = cmd_wr && obj_ok && (state == XS_IDLE);
  assign busy   = (state != XS_IDLE);
  assign apply  = (state == XS_APPLY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= XS_IDLE;
      cmd_q <= '0;
      obj_q <= '0;
    end else begin
      unique case (state)
        XS_IDLE: begin
          if (accept) begin
            state <= XS_FETCH;
            cmd_q <= cmd_mask_in;
            obj_q <= cmd_obj_in;
          end
        end
        XS_FETCH: state <= XS_APPLY;
        XS_APPLY: state <= XS_IDLE;
        default:  state <= XS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/msgxfer_merge.sv
module msgxfer_merge
  import msgxfer_pkg::*;
(
  input  logic [7:0] cmd,
  input  obj_t       ram_w,
  input  obj_t       if_w,
  output obj_t       ram_new,
  output obj_t       if_new
);

  always_comb begin
    ram_new = ram_w;
    if_new  = if_w;
    if (cmd[CM_DIR]) begin
      if (cmd[CM_MSK]) ram_new.msk = if_w.msk;
      if (cmd[CM_ARB]) ram_new.arb = if_w.arb;
      if (cmd[CM_CTL]) ram_new.ctl = if_w.ctl;
      if (cmd[CM_DA])  ram_new.da  = if_w.da;
      if (cmd[CM_DB])  ram_new.db  = if_w.db;
      if (cmd[CM_TXND]) ram_new.ctl[MC_TXRQ] = 1'b1;
    end else begin
      if (cmd[CM_MSK]) if_new.msk = ram_w.msk;
      if (cmd[CM_ARB]) if_new.arb = ram_w.arb;
      if (cmd[CM_CTL]) if_new.ctl = ram_w.ctl;
      if (cmd[CM_DA])  if_new.da  = ram_w.da;
      if (cmd[CM_DB])  if_new.db  = ram_w.db;
      if (cmd[CM_CIP])  ram_new.ctl[MC_INTPND] = 1'b0;
      if (cmd[CM_TXND]) ram_new.ctl[MC_NEWDAT] = 1'b0;
    end
  end

endmodule

// File: rtl/msgxfer_engine.sv
module msgxfer_engine
  import msgxfer_pkg::*;
#(
  parameter int NUM_OBJ = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        busy
);

  localparam int OBJ_W = $clog2(NUM_OBJ + 1);
  localparam int AW    = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1;
  localparam int PAD_W = 15 - OBJ_W;
  localparam int OBJ_BITS = $bits(obj_t);

  logic             cmd_wr;
  logic             apply;
  logic [7:0]       cmd_q;
  logic [OBJ_W-1:0] obj_q;
  logic [OBJ_W-1:0] obj_m1;
  logic [AW-1:0]    ram_idx;
  obj_t             if_q;
  obj_t             ram_rd;
  obj_t             ram_new;
  obj_t             if_new;
  logic [OBJ_BITS-1:0] ram_rd_raw;

  assign cmd_wr  = wr_en && (reg_addr_e'(wr_addr) == RA_CMD);
  assign obj_m1  = obj_q - OBJ_W'(1);
  assign ram_idx = obj_m1[AW-1:0];
  assign ram_rd  = obj_t'(ram_rd_raw);

  msgxfer_ctrl #(.NUM_OBJ(NUM_OBJ)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_mask_in (wr_data[23:16]),
    .cmd_obj_in  (wr_data[OBJ_W-1:0]),
    .busy        (busy),
    .apply       (apply),
    .cmd_q       (cmd_q),
    .obj_q       (obj_q)
  );

  msgxfer_ram #(.DEPTH(NUM_OBJ), .WIDTH(OBJ_BITS)) u_ram (
    .clk   (clk),
    .we    (apply),
    .waddr (ram_idx),
    .wdata (ram_new),
    .raddr (ram_idx),
    .rdata (ram_rd_raw)
  );

  msgxfer_merge u_merge (
    .cmd     (cmd_q),
    .ram_w   (ram_rd),
    .if_w    (if_q),
    .ram_new (ram_new),
    .if_new  (if_new)
  );

  // interface registers: host writes when idle, engine loads on read apply
  always_ff @(posedge clk) begin
    if (rst) begin
      if_q <= '0;
    end else if (apply) begin
      if (!cmd_q[CM_DIR]) if_q <= if_new;
    end else if (wr_en && !busy) begin
      case (reg_addr_e'(wr_addr))
        RA_MSK:  if_q.msk <= wr_data;
        RA_ARB:  if_q.arb <= wr_data;
        RA_CTL:  if_q.ctl <= wr_data[CTL_W-1:0];
        RA_DA:   if_q.da  <= wr_data;
        RA_DB:   if_q.db  <= wr_data;
        default: ;
      endcase
    end
  end

  // registered readback
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (reg_addr_e'(rd_addr))
        RA_CMD:  rd_data <= {8'h00, cmd_q, busy, {PAD_W{1'b0}}, obj_q};
        RA_MSK:  rd_data <= if_q.msk;
        RA_ARB:  rd_data <= if_q.arb;
        RA_CTL:  rd_data <= {{(32-CTL_W){1'b0}}, if_q.ctl};
        RA_DA:   rd_data <= if_q.da;
        RA_DB:   rd_data <= if_q.db;
        default: rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/msgxfer_engine_chk.sv
module msgxfer_engine_chk #(
  parameter int NUM_OBJ = 32,
  localparam int OBJ_W = $clog2(NUM_OBJ + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic             busy,
  input logic [OBJ_W-1:0] obj_q
);

  logic             cmd_hit;
  logic [OBJ_W-1:0] req_obj;
  logic             req_ok;

  assign cmd_hit = wr_en && (wr_addr == 3'd0);
  assign req_obj = wr_data[OBJ_W-1:0];
  assign req_ok  = (req_obj != '0) && (req_obj <= OBJ_W'(NUM_OBJ));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !busy && req_ok) |=> busy);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  assert_len_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  assert_badobj_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !busy && !req_ok) |=> !busy);

  assert_locked_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(obj_q)));

endmodule

bind msgxfer_engine msgxfer_engine_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .busy    (busy),
  .obj_q   (obj_q)
);

// File: tb/msgxfer_engine_tb.sv
module msgxfer_engine_tb;

  localparam int NOBJ = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        busy;

  int checks = 0;
  int bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  msgxfer_engine #(.NUM_OBJ(NOBJ)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  // behavioural reference model
  logic [31:0] m_msk [1:NOBJ];
  logic [31:0] m_arb [1:NOBJ];
  logic [15:0] m_ctl [1:NOBJ];
  logic [31:0] m_da  [1:NOBJ];
  logic [31:0] m_db  [1:NOBJ];
  logic [31:0] i_msk, i_arb, i_da, i_db;
  logic [15:0] i_ctl;
  logic [7:0]  m_cmd;
  int          m_obj;
  int          m_cnt;
  logic        m_busy;
  logic [31:0] exp_rd;
  logic        rd_chk;

  function automatic logic [31:0] model_read(input logic [2:0] a, input logic b);
    case (a)
      3'd0: return {8'h00, m_cmd, b, 9'b0, 6'(m_obj)};
      3'd1: return i_msk;
      3'd2: return i_arb;
      3'd3: return {16'h0, i_ctl};
      3'd4: return i_da;
      3'd5: return i_db;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      i_msk = 0; i_arb = 0; i_ctl = 0; i_da = 0; i_db = 0;
      m_cmd = 0; m_obj = 0; m_cnt = 0; exp_rd = 0; rd_chk = 0;
    end else begin
      automatic logic bz = (m_cnt != 0);
      rd_chk = rd_en;
      if (rd_en) exp_rd = model_read(rd_addr, bz);
      if (m_cnt == 1) begin
        if (m_cmd[7]) begin
          if (m_cmd[6]) m_msk[m_obj] = i_msk;
          if (m_cmd[5]) m_arb[m_obj] = i_arb;
          if (m_cmd[4]) m_ctl[m_obj] = i_ctl;
          if (m_cmd[1]) m_da[m_obj]  = i_da;
          if (m_cmd[0]) m_db[m_obj]  = i_db;
          if (m_cmd[2]) m_ctl[m_obj][8] = 1'b1;
        end else begin
          if (m_cmd[6]) i_msk = m_msk[m_obj];
          if (m_cmd[5]) i_arb = m_arb[m_obj];
          if (m_cmd[4]) i_ctl = m_ctl[m_obj];
          if (m_cmd[1]) i_da  = m_da[m_obj];
          if (m_cmd[0]) i_db  = m_db[m_obj];
          if (m_cmd[3]) m_ctl[m_obj][13] = 1'b0;
          if (m_cmd[2]) m_ctl[m_obj][15] = 1'b0;
        end
      end
      if (m_cnt > 0) m_cnt--;
      if (wr_en && !bz) begin
        case (wr_addr)
          3'd0: if (wr_data[5:0] >= 1 && int'(wr_data[5:0]) <= NOBJ) begin
                  m_cmd = wr_data[23:16]; m_obj = int'(wr_data[5:0]); m_cnt = 2;
                end
          3'd1: i_msk = wr_data;
          3'd2: i_arb = wr_data;
          3'd3: i_ctl = wr_data[15:0];
          3'd4: i_da  = wr_data;
          3'd5: i_db  = wr_data;
          default: ;
        endcase
      end
    end
    m_busy = (m_cnt != 0);
  end

  // comparison on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (busy !== m_busy) begin
        bad++;
        $display("FAIL %s busy: actual=%0b expected=%0b", cur_req, busy, m_busy);
      end
      if (rd_chk) begin
        checks++;
        if (rd_data !== exp_rd) begin
          bad++;
          $display("FAIL %s rd_data: actual=%h expected=%h", cur_req, rd_data, exp_rd);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] m, input logic [5:0] o);
    wr(3'd0, {8'h00, m, 10'h000, o});
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_all();
    for (int a = 0; a < 8; a++) rd(3'(a));
  endtask

  task automatic load_if(input logic [31:0] k, input logic [15:0] c);
    wr(3'd1, k ^ 32'h1FFF_0000);
    wr(3'd2, 32'hA000_0000 | (32'h123 << 18) | k);
    wr(3'd3, {16'h0, c});
    wr(3'd4, k ^ 32'h1122_3344);
    wr(3'd5, k ^ 32'h5566_7788);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    cur_req = "R1";
    rd_all();

    cur_req = "R4";
    load_if(32'h0, 16'h0A08);
    cmd(8'hF3, 6'd3);
    load_if(32'h0F0F_0F0F, 16'h1111);
    cur_req = "R6";
    cmd(8'h73, 6'd3);
    rd_all();

    cur_req = "R4";
    wr(3'd2, 32'hC000_1234);
    wr(3'd1, 32'hDEAD_BEEF);
    cmd(8'hA0, 6'd3);
    load_if(32'h3333_0000, 16'h7777);
    cmd(8'h73, 6'd3);
    rd_all();

    cur_req = "R5";
    load_if(32'h0000_0505, 16'h2080);
    cmd(8'hF3, 6'd5);
    cmd(8'h84, 6'd5);
    cmd(8'h88, 6'd5);
    wr(3'd3, 32'h0);
    cmd(8'h10, 6'd5);
    rd(3'd3);

    cur_req = "R7";
    wr(3'd3, 32'h0000_A008);
    cmd(8'h90, 6'd7);
    wr(3'd3, 32'h0);
    cmd(8'h1C, 6'd7);
    rd(3'd3);
    cmd(8'h10, 6'd7);
    rd(3'd3);

    cur_req = "R6";
    wr(3'd4, 32'hCAFE_0001);
    wr(3'd5, 32'hBEEF_0002);
    cmd(8'h02, 6'd3);
    rd(3'd4);
    rd(3'd5);

    cur_req = "R8";
    cmd(8'hF3, 6'd0);
    rd(3'd0);
    cmd(8'hF3, 6'd33);
    rd(3'd0);
    cmd(8'h73, 6'd3);
    rd_all();

    cur_req = "R2";
    load_if(32'h0000_2020, 16'h0C0C);
    cmd(8'hF3, 6'd32);
    load_if(32'h4444_4444, 16'h0);
    cmd(8'h73, 6'd32);
    rd_all();

    cur_req = "R3";
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = {8'h0, 8'h53, 10'h0, 6'd5};
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; rd_addr = 3'd0;
    @(negedge clk); rd_addr = 3'd0;
    @(negedge clk); rd_en = 1'b0;
    rd(3'd0);

    cur_req = "R9";
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = {8'h0, 8'h73, 10'h0, 6'd3};
    @(negedge clk); wr_data = {8'h0, 8'hF3, 10'h0, 6'd5};
    @(negedge clk); wr_addr = 3'd1; wr_data = 32'h9999_9999;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rd_all();
    cmd(8'h73, 6'd5);
    rd_all();

    cur_req = "R10";
    rd(3'd6);
    rd(3'd7);
    rd(3'd3);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule